// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general-purpose and status register storage for a 32-bit processor with seven operating modes. Software names sixteen registers, 0 to 15, with a 4-bit index. Which physical copy an index reaches depends on the current mode. The fast-interrupt mode has a private set of registers 8 to 14. Each of the other exception modes has a private stack pointer (register 13) and link register (register 14). System mode and user mode share the same bank.

There are two combinational read ports and one write port, which commits on the rising clock edge. Beside them are a current status register and five saved status registers, one per exception mode, each with its own read and write path. A narrow-state input models the compressed 16-bit instruction state. In that state, registers 8 to 12 cannot be reached, while registers 13, 14 and 15 map exactly as they do in the wide state.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high on a rising edge, all general registers and all saved status registers are cleared. The current status register becomes 32'h0000_00D3: mode field bits [4:0] = 10011 (supervisor), IRQ mask bit 7 = 1, fast-interrupt mask bit 6 = 1.
- R2: Indices 0 to 7 and index 15 reach a single physical copy in every mode.
- R3: In fast-interrupt mode (`mode_i` = 10001), indices 8 to 14 reach private copies that no other mode can see.
- R4: In IRQ (10010), supervisor (10011), abort (10111) and undefined (11011) mode, indices 13 and 14 reach copies private to that mode. Indices 8 to 12 reach the user copies.
- R5: System mode (11111), user mode (10000) and any unlisted `mode_i` value all use the user bank.
- R6: Each of the five exception modes has its own saved status register, read on `spsr_rd` and written through `spsr_we`/`spsr_wdata`.
- R7: In user mode, system mode or any unlisted mode, `spsr_rd` reads zero and `spsr_we` changes no saved status register.
- R8: With `narrow_i` = 1, indices 8 to 12 read zero on both ports and a write to them changes nothing. Indices 13 to 15 map as in the wide state.
- R9: Reads are combinational. A write is visible from the next rising edge on. A read of the register being written in the same cycle returns the old value. The two read ports are independent.
- R10: `cpsr_we` loads `cpsr_wdata` into the current status register on the rising edge. Otherwise the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode encoding |
| narrow_i | input | 1 | 1 = compressed instruction state view |
| rd_idx_a | input | 4 | Read port A register index |
| rd_a | output | 32 | Read port A data |
| rd_idx_b | input | 4 | Read port B register index |
| rd_b | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| cpsr_we | input | 1 | Current status register write enable |
| cpsr_wdata | input | 32 | Current status register write data |
| cpsr_rd | output | 32 | Current status register value |
| spsr_we | input | 1 | Saved status register write enable for the current mode |
| spsr_wdata | input | 32 | Saved status register write data |
| spsr_rd | output | 32 | Saved status register of the current mode |

## Verification
The bench aims at the places where a mode's bank leaks into another mode:
- A fast-interrupt write to register 9 must not reach the user copy. A design that banked only registers 13 and 14 would show the value in user mode.
- A supervisor stack pointer must stay hidden from system mode. A design that gave system mode its own bank would return the wrong copy.
- An unlisted mode encoding must fall back to the user bank.

It also targets saved status writes made in user mode, and narrow-state writes to registers 8 to 12. A design that failed to drop either would later show the stray data in a mode that can read it. Same-cycle read-after-write is exercised to catch a bypass that returns the new value early.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int XLEN      = 32;
    localparam int IDXW      = 4;
    localparam int MODEW     = 5;
    localparam int FIQ_LO    = 8;
    localparam int FIQ_HI    = 14;
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;
    localparam int NUSER     = 1 << IDXW;
    localparam int NFIQ      = FIQ_HI - FIQ_LO + 1;
    localparam int NPRIV     = 4;
    localparam int NPHYS     = NUSER + NFIQ + 2 * NPRIV;
    localparam int PW        = $clog2(NPHYS);
    localparam int FIQ_BASE  = NUSER;
    localparam int PRIV_BASE = NUSER + NFIQ;
    localparam int NSAVED    = NPRIV + 1;
    localparam int SW        = $clog2(NSAVED);

    localparam logic [XLEN-1:0] CPSR_RST = 32'h0000_00D3;

    typedef enum logic [MODEW-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        BK_USER = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    typedef struct packed {
        logic          hit;
        logic [PW-1:0] slot;
    } route_t;

    function automatic bank_e bank_of(logic [MODEW-1:0] m);
        case (m)
            MD_FIQ:  return BK_FIQ;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_USER;
        endcase
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
    import bank_pkg::*;
#(
    parameter int IW = IDXW,
    parameter int MW = MODEW
) (
    input  logic [MW-1:0] mode,
    input  logic          narrow,
    input  logic [IW-1:0] idx,
    output route_t        route
);

    bank_e bank;
    int    ix;

    always_comb begin
        bank       = bank_of(mode);
        ix         = int'(idx);
        route.hit  = 1'b1;
        route.slot = PW'(ix);
        if (narrow && ix >= FIQ_LO && ix < SP_IDX) begin
            route.hit  = 1'b0;
            route.slot = '0;
        end else if (bank == BK_FIQ && ix >= FIQ_LO && ix <= FIQ_HI) begin
            route.slot = PW'(FIQ_BASE + ix - FIQ_LO);
        end else if (bank != BK_USER && bank != BK_FIQ &&
                     (ix == SP_IDX || ix == LR_IDX)) begin
            route.slot = PW'(PRIV_BASE + 2 * (int'(bank) - int'(BK_IRQ)) + ix - SP_IDX);
        end
    end

endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import bank_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NPHYS,
    parameter int SL = PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SL-1:0] wslot,
    input  logic [W-1:0]  wdata,
    input  logic [SL-1:0] rslot_a,
    input  logic [SL-1:0] rslot_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wslot] <= wdata;
        end
    end

    assign rdata_a = mem[rslot_a];
    assign rdata_b = mem[rslot_b];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(wslot)] == $past(wdata)); // R9

endmodule

// File: rtl/psr_store.sv
module psr_store
    import bank_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NS = NSAVED,
    parameter int SS = SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpsr_we,
    input  logic [W-1:0]  cpsr_wdata,
    output logic [W-1:0]  cpsr_q,
    input  logic          spsr_hit,
    input  logic [SS-1:0] spsr_sel,
    input  logic          spsr_we,
    input  logic [W-1:0]  spsr_wdata,
    output logic [W-1:0]  spsr_rdata
);

    logic [W-1:0] saved [NS];

    always_ff @(posedge clk) begin
        if (rst) cpsr_q <= CPSR_RST;
        else if (cpsr_we) cpsr_q <= cpsr_wdata;
    end

    for (genvar g = 0; g < NS; g++) begin : g_saved
        always_ff @(posedge clk) begin
            if (rst) saved[g] <= '0;
            else if (spsr_we && spsr_hit && spsr_sel == SS'(g)) saved[g] <= spsr_wdata;
        end

        AST_SPSR_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            !(spsr_hit && spsr_sel == SS'(g)) |=> $stable(saved[g])); // R7
    end

    assign spsr_rdata = spsr_hit ? saved[spsr_sel] : '0;

    AST_CPSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cpsr_we |=> $stable(cpsr_q)); // R10

    AST_CPSR_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cpsr_q == CPSR_RST); // R1

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MODEW-1:0] mode_i,
    input  logic             narrow_i,
    input  logic [IDXW-1:0]  rd_idx_a,
    output logic [XLEN-1:0]  rd_a,
    input  logic [IDXW-1:0]  rd_idx_b,
    output logic [XLEN-1:0]  rd_b,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             cpsr_we,
    input  logic [XLEN-1:0]  cpsr_wdata,
    output logic [XLEN-1:0]  cpsr_rd,
    input  logic             spsr_we,
    input  logic [XLEN-1:0]  spsr_wdata,
    output logic [XLEN-1:0]  spsr_rd
);

    localparam int NPORT = 3;

    logic [IDXW-1:0] port_idx [NPORT];
    route_t          port_rt  [NPORT];
    logic [XLEN-1:0] raw_a, raw_b;
    bank_e           cur_bank;
    logic            spsr_hit;
    logic [SW-1:0]   spsr_sel;

    assign port_idx[0] = rd_idx_a;
    assign port_idx[1] = rd_idx_b;
    assign port_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bank_map #(.IW(IDXW), .MW(MODEW)) u_map (
            .mode   (mode_i),
            .narrow (narrow_i),
            .idx    (port_idx[p]),
            .route  (port_rt[p])
        );
    end

    gpr_store #(.W(XLEN), .N(NPHYS), .SL(PW)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en && port_rt[2].hit),
        .wslot   (port_rt[2].slot),
        .wdata   (wr_data),
        .rslot_a (port_rt[0].slot),
        .rslot_b (port_rt[1].slot),
        .rdata_a (raw_a),
        .rdata_b (raw_b)
    );

    assign rd_a = port_rt[0].hit ? raw_a : '0;
    assign rd_b = port_rt[1].hit ? raw_b : '0;

    assign cur_bank = bank_of(mode_i);
    assign spsr_hit = (cur_bank != BK_USER);
    assign spsr_sel = spsr_hit ? SW'(int'(cur_bank) - int'(BK_FIQ)) : '0;

    psr_store #(.W(XLEN), .NS(NSAVED), .SS(SW)) u_psr (
        .clk        (clk),
        .rst        (rst),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .cpsr_q     (cpsr_rd),
        .spsr_hit   (spsr_hit),
        .spsr_sel   (spsr_sel),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .spsr_rdata (spsr_rd)
    );

    AST_SPSR_USER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_USR || mode_i == MD_SYS) |-> spsr_rd == '0); // R7

    AST_NARROW_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (narrow_i && rd_idx_a >= 4'd8 && rd_idx_a <= 4'd12) |-> rd_a == '0); // R8

    AST_PC_SHARED: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == 4'd15 && rd_idx_b == 4'd15) |-> rd_a == rd_b); // R2

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  mode_i;
    logic        narrow_i;
    logic [3:0]  rd_idx_a, rd_idx_b, wr_idx;
    logic [31:0] rd_a, rd_b, wr_data, cpsr_wdata, cpsr_rd, spsr_wdata, spsr_rd;
    logic        wr_en, cpsr_we, spsr_we;

    always #2 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .narrow_i(narrow_i),
        .rd_idx_a(rd_idx_a), .rd_a(rd_a), .rd_idx_b(rd_idx_b), .rd_b(rd_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_rd(cpsr_rd),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rd(spsr_rd)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [31:0] gm [31];
    logic [31:0] cm;
    logic [31:0] sm [5];

    logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00101};

    function automatic int bank_num(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int gslot(logic [4:0] m, logic nw, logic [3:0] i);
        int b = bank_num(m);
        if (nw && i >= 8 && i <= 12) return -1;
        if (b == 1 && i >= 8 && i != 15) return 16 + int'(i) - 8;
        if (b >= 2 && (i == 13 || i == 14)) return 23 + (b - 2) * 2 + int'(i) - 13;
        return int'(i);
    endfunction

    function automatic string tag_for(logic [4:0] m, logic nw, logic [3:0] i);
        int b = bank_num(m);
        if (nw && i >= 8 && i <= 12) return "R8";
        if (i < 8 || i == 15) return "R2";
        if (b == 1) return "R3";
        if (b >= 2) return "R4";
        return "R5";
    endfunction

    function automatic logic [31:0] gexp(logic [4:0] m, logic nw, logic [3:0] i);
        int s = gslot(m, nw, i);
        return (s < 0) ? 32'h0 : gm[s];
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic step(logic [4:0] m, logic nw, logic [3:0] ia, logic [3:0] ib,
                        logic we, logic [3:0] iw, logic [31:0] wd,
                        logic cwe, logic [31:0] cwd, logic swe, logic [31:0] swd);
        int b, s;
        mode_i = m; narrow_i = nw; rd_idx_a = ia; rd_idx_b = ib;
        wr_en = we; wr_idx = iw; wr_data = wd;
        cpsr_we = cwe; cpsr_wdata = cwd; spsr_we = swe; spsr_wdata = swd;
        #1;
        b = bank_num(m);
        chk(tag_for(m, nw, ia), rd_a, gexp(m, nw, ia), "port A");
        chk(we && iw == ib ? "R9" : tag_for(m, nw, ib), rd_b, gexp(m, nw, ib), "port B");
        chk("R10", cpsr_rd, cm, "cpsr");
        chk(b == 0 ? "R7" : "R6", spsr_rd, (b == 0) ? 32'h0 : sm[b - 1], "spsr");
        @(posedge clk);
        s = gslot(m, nw, iw);
        if (we && s >= 0) gm[s] = wd;
        if (cwe) cm = cwd;
        if (swe && b != 0) sm[b - 1] = swd;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        mode_i = 5'b10000; narrow_i = 0; rd_idx_a = 0; rd_idx_b = 0;
        wr_en = 0; wr_idx = 0; wr_data = 0;
        cpsr_we = 0; cpsr_wdata = 0; spsr_we = 0; spsr_wdata = 0;
        for (int i = 0; i < 31; i++) gm[i] = '0;
        for (int i = 0; i < 5; i++) sm[i] = '0;
        cm = 32'h0000_00D3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", cpsr_rd, 32'h0000_00D3, "cpsr after reset");
        for (int i = 0; i < 16; i++) begin
            rd_idx_a = 4'(i); rd_idx_b = 4'(15 - i); #1;
            chk("R1", rd_a, 32'h0, "reg after reset");
        end
        mode_i = 5'b10011; #1;
        chk("R1", spsr_rd, 32'h0, "spsr after reset");
        @(negedge clk);

        // R3: fiq private high registers
        step(5'b10001, 0, 9, 9, 1, 9, 32'hF1F1_0009, 0, 0, 0, 0);
        step(5'b10000, 0, 9, 9, 0, 0, 0, 0, 0, 0, 0);
        step(5'b10001, 0, 9, 14, 0, 0, 0, 0, 0, 0, 0);
        // R4/R5: supervisor sp hidden from system, bogus mode uses user bank
        step(5'b10011, 0, 13, 13, 1, 13, 32'h5AC0_0013, 0, 0, 0, 0);
        step(5'b11111, 0, 13, 13, 1, 13, 32'h0575_0013, 0, 0, 0, 0);
        step(5'b00101, 0, 13, 13, 0, 0, 0, 0, 0, 0, 0);
        step(5'b10011, 0, 13, 8, 1, 8, 32'h0000_0888, 0, 0, 0, 0);
        step(5'b10010, 0, 8, 13, 0, 0, 0, 0, 0, 0, 0);
        // R9: same-cycle read returns old value
        step(5'b10000, 0, 5, 5, 1, 5, 32'hAAAA_0005, 0, 0, 0, 0);
        step(5'b10000, 0, 5, 5, 1, 5, 32'hBBBB_0005, 0, 0, 0, 0);
        step(5'b10000, 0, 5, 5, 0, 0, 0, 0, 0, 0, 0);
        // R6/R7: saved status per mode, ignored in user/system
        step(5'b10010, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1111_0012);
        step(5'b11011, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h2222_001B);
        step(5'b10000, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_0010);
        step(5'b11111, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_001F);
        for (int k = 1; k < 6; k++) step(modes[k], 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: narrow state blocks 8..12, keeps 13..15
        step(5'b10000, 0, 10, 10, 1, 10, 32'h0000_0A0A, 0, 0, 0, 0);
        step(5'b10000, 1, 10, 13, 1, 10, 32'hBAD0_0A0A, 0, 0, 0, 0);
        step(5'b10000, 0, 10, 10, 0, 0, 0, 0, 0, 0, 0);
        step(5'b10011, 1, 13, 15, 1, 15, 32'h0000_1000, 0, 0, 0, 0);
        step(5'b10001, 0, 15, 13, 0, 0, 0, 0, 0, 0, 0);
        // R10: status register write
        step(5'b10000, 0, 0, 0, 0, 0, 0, 1, 32'h6000_0010, 0, 0);
        step(5'b10000, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0);

        for (int n = 0; n < 1500; n++) begin
            step(modes[$urandom_range(0, 7)], ($urandom_range(0, 3) == 0),
                 4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom,
                 ($urandom_range(0, 7) == 0), $urandom,
                 ($urandom_range(0, 3) == 0), $urandom);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule